// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the address-latch strobe, the active-low program-fetch strobe and the high-address port value of a multiplexed external memory bus. It runs directly from the oscillator clock and divides it into machine cycles of twelve periods, numbered 0 to 11. A machine-cycle strobe marks period 0 so that the surrounding sequencer can present a new set of cycle attributes once per machine cycle.

The attributes are the level of the external-access pin, a flag for an external data transfer, a flag for a code-table read, an address-width select, the high address byte and the port-2 register value. A software-controlled suppress bit quiets the address-latch strobe when the bus is idle. Decoding instructions and moving data are done elsewhere.

The address-latch strobe normally pulses twice per machine cycle. A data transfer removes its second pulse and both program-fetch strobes. The suppress bit does not act during a data transfer or a code-table read, and does not act while code runs from external memory.

Top module: `xbus_strobe_gen`

## Requirements
- R1: `mc_stb` is high for exactly one period in every 12, in period 0. The first period after reset is released is period 0.
- R2: With the strobe enabled and no data transfer, `ale` is high in periods 0, 1, 6 and 7 and low otherwise.
- R3: During a data-transfer cycle (`xdata_cyc`=1), `ale` is high only in periods 0 and 1.
- R4: When `ale_off`=1, `ea_high`=1, `xdata_cyc`=0 and `tbl_cyc`=0, `ale` is held high for the whole machine cycle.
- R5: `ale_off` has no effect in a cycle with `xdata_cyc`=1 or `tbl_cyc`=1, and `ale` follows R2/R3.
- R6: `ale_off` has no effect when `ea_high`=0 (external execution).
- R7: With `ea_high`=0 and `xdata_cyc`=0, `psen_n` is low in periods 2, 3, 4, 8, 9 and 10 and high otherwise.
- R8: With `ea_high`=1, `psen_n` stays high for the whole cycle.
- R9: In a cycle with `xdata_cyc`=1, `psen_n` stays high for the whole cycle.
- R10: `p2_out` equals `hi_addr` when `wide_addr`=1 and equals `p2_reg` when `wide_addr`=0.
- R11: While `rst_n` is low with `ale_off`=0 and `ea_high`=1, `ale`=0, `psen_n`=1 and `mc_stb`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ea_high | input | 1 | External-access pin level; 1 means code is fetched internally |
| xdata_cyc | input | 1 | Current machine cycle is an external data transfer |
| tbl_cyc | input | 1 | Current machine cycle is a code-table read |
| wide_addr | input | 1 | 1 selects a 16-bit address and 0 selects an 8-bit indirect address |
| hi_addr | input | 8 | High byte of the 16-bit address |
| p2_reg | input | 8 | Port-2 register contents |
| ale_off | input | 1 | Software bit that suppresses the idle address-latch strobe |
| ale | output | 1 | Address-latch strobe |
| psen_n | output | 1 | Program-fetch strobe, active low |
| p2_out | output | 8 | Port-2 output value |
| mc_stb | output | 1 | High in period 0 of each machine cycle |

## Verification
The assertions assume that the cycle attributes (`ea_high`, `xdata_cyc`, `tbl_cyc`, `ale_off`) stay constant through a machine cycle. The checks made in period 0 and on strobe overlap rely on this. The stimulus changes these inputs only in the half-period after the period-11 sample and before the next period 0 begins. It sets each combination for one full machine cycle: internal and external execution, narrow and wide data transfers, and table reads with the suppress bit both set and clear.

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen #(
  parameter int PERIODS = 12,
  parameter int ALE_W   = 2,
  parameter int PSEN_W  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ea_high,
  input  logic       xdata_cyc,
  input  logic       tbl_cyc,
  input  logic       wide_addr,
  input  logic [7:0] hi_addr,
  input  logic [7:0] p2_reg,
  input  logic       ale_off,
  output logic       ale,
  output logic       psen_n,
  output logic [7:0] p2_out,
  output logic       mc_stb
);
  localparam int PW   = $clog2(PERIODS);
  localparam int HALF = PERIODS / 2;
  localparam int LAST = PERIODS - 1;

  logic [PW-1:0] ph;
  logic [PW-1:0] sub;
  logic          first_half;
  logic          ale_win, psen_win, ale_on, ext_exec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                ph <= PW'(LAST);
    else if (ph == PW'(LAST))  ph <= '0;
    else                       ph <= ph + 1'b1;

  assign first_half = ph < PW'(HALF);
  assign sub        = first_half ? ph : ph - PW'(HALF);
  assign ale_win    = sub < PW'(ALE_W);
  assign psen_win   = (sub >= PW'(ALE_W)) && (sub < PW'(ALE_W + PSEN_W));

  assign ext_exec = ~ea_high;
  assign ale_on   = ~ale_off | ext_exec | xdata_cyc | tbl_cyc;

  assign ale    = ale_on ? (ale_win & (first_half | ~xdata_cyc)) : 1'b1;
  assign psen_n = ~(ext_exec & ~xdata_cyc & psen_win);
  assign p2_out = wide_addr ? hi_addr : p2_reg;
  assign mc_stb = (ph == '0);
endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk #(
  parameter int PERIODS = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ea_high,
  input logic       xdata_cyc,
  input logic       tbl_cyc,
  input logic       wide_addr,
  input logic [7:0] hi_addr,
  input logic [7:0] p2_reg,
  input logic       ale_off,
  input logic       ale,
  input logic       psen_n,
  input logic [7:0] p2_out,
  input logic       mc_stb
);
  localparam int CW = $clog2(PERIODS) + 1;
  logic [CW-1:0] cnt;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (mc_stb) begin
      cnt  <= '0;
      seen <= 1'b1;
    end else if (cnt != CW'(PERIODS)) begin
      cnt <= cnt + 1'b1;
    end

  a_r1_stb_period: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !mc_stb && cnt == CW'(PERIODS - 2)) |=> mc_stb);
  a_r1_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    mc_stb |=> !mc_stb);
  a_r2_ale_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    mc_stb |-> ale);
  a_r4_ale_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_off && ea_high && !xdata_cyc && !tbl_cyc) |-> ale);
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !psen_n));
  a_r8_psen_internal: assert property (@(posedge clk) disable iff (!rst_n)
    ea_high |-> psen_n);
  a_r9_psen_xdata: assert property (@(posedge clk) disable iff (!rst_n)
    xdata_cyc |-> psen_n);
  a_r10_p2_select: assert property (@(posedge clk) disable iff (!rst_n)
    p2_out == (wide_addr ? hi_addr : p2_reg));
endmodule

bind xbus_strobe_gen xbus_strobe_chk #(.PERIODS(PERIODS)) chk_i (
  .clk(clk), .rst_n(rst_n), .ea_high(ea_high), .xdata_cyc(xdata_cyc),
  .tbl_cyc(tbl_cyc), .wide_addr(wide_addr), .hi_addr(hi_addr),
  .p2_reg(p2_reg), .ale_off(ale_off), .ale(ale), .psen_n(psen_n),
  .p2_out(p2_out), .mc_stb(mc_stb)
);

// File: tb/xbus_strobe_gen_tb.sv
module xbus_strobe_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ea_high = 1'b1, xdata_cyc = 1'b0, tbl_cyc = 1'b0;
  logic       wide_addr = 1'b0, ale_off = 1'b0;
  logic [7:0] hi_addr = 8'h00, p2_reg = 8'h00;
  logic       ale, psen_n, mc_stb;
  logic [7:0] p2_out;

  int n_cmp = 0, n_bad = 0;

  typedef struct packed {
    logic       ale;
    logic       psen_n;
    logic       mc;
    logic [7:0] p2;
    logic [3:0] ph;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ea_high(ea_high), .xdata_cyc(xdata_cyc),
    .tbl_cyc(tbl_cyc), .wide_addr(wide_addr), .hi_addr(hi_addr),
    .p2_reg(p2_reg), .ale_off(ale_off), .ale(ale), .psen_n(psen_n),
    .p2_out(p2_out), .mc_stb(mc_stb)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input int ph);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s period %0d: actual %h expected %h", req, ph, act, exp);
    end
  endtask

  // Driver: applies one machine cycle's attributes and queues 12 expected items.
  task automatic drive_cycle(input logic ea, input logic xd, input logic tb,
                             input logic wd, input logic off,
                             input logic [7:0] ha, input logic [7:0] pr);
    ea_high = ea; xdata_cyc = xd; tbl_cyc = tb; wide_addr = wd;
    ale_off = off; hi_addr = ha; p2_reg = pr;
    for (int k = 0; k < 12; k++) begin
      exp_t e;
      logic pulse, on;
      pulse = (k == 0 || k == 1) || (!xd && (k == 6 || k == 7));
      on    = !off || !ea || xd || tb;
      e.ale    = on ? pulse : 1'b1;
      e.psen_n = !(!ea && !xd && ((k >= 2 && k <= 4) || (k >= 8 && k <= 10)));
      e.mc     = (k == 0);
      e.p2     = wd ? ha : pr;
      e.ph     = 4'(k);
      q.push_back(e);
    end
    repeat (12) @(negedge clk);
  endtask

  // Monitor: samples a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check("R1 mc_stb", {7'd0, mc_stb}, {7'd0, e.mc}, e.ph);
        check(ale_off ? "R4/R5/R6 ale" : (xdata_cyc ? "R3 ale" : "R2 ale"),
              {7'd0, ale}, {7'd0, e.ale}, e.ph);
        check(ea_high ? "R8 psen_n" : (xdata_cyc ? "R9 psen_n" : "R7 psen_n"),
              {7'd0, psen_n}, {7'd0, e.psen_n}, e.ph);
        check("R10 p2_out", p2_out, e.p2, e.ph);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 ale", {7'd0, ale}, 8'd0, 0);
    check("R11 psen_n", {7'd0, psen_n}, 8'd1, 0);
    check("R11 mc_stb", {7'd0, mc_stb}, 8'd0, 0);
    rst_n = 1'b1;
    //          ea    xd    tb    wd    off
    drive_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C); // R2 R8 R10
    drive_cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h12, 8'h3C); // R7 R10
    drive_cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 8'h77); // R3 R9
    drive_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3, 8'h77); // R3 R10
    drive_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hFF); // R4
    drive_cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hFF); // R5
    drive_cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81, 8'h18); // R5 R3
    drive_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 8'h18); // R6 R7
    drive_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h99, 8'h42); // R6 R9
    drive_cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hE7, 8'h42); // R8 R10
    drive_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h01); // R4 again
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule